// File: doc/BRIEF.md
# Cache Region Property Lookup

This block turns a physical memory address into the 8-bit property code that a cache controller applies to the access. The code might mean cacheable, write-through, write-protected and so on. The block does not interpret the code. It only decides which programmed setting owns the address.

The base decision comes from one packed 64-bit default word. That word holds two page thresholds, top of system memory and ROM base, and splits the address space into three zones: system, device and ROM. Two kinds of setting can override the base zones:

- A fixed legacy window covering 0xA0000 to 0xFFFFF, split into six 64 KB blocks, each with its own code.
- A bank of programmable page ranges. These may overlap one another.

Configuration is written through a simple word-select write port. Lookups are registered, so the result appears one cycle after the address is presented.

Top module: `cache_region_lookup`

## Requirements
- R1: After reset `res_valid` is 0 and `res_prop` is 0x00. All setting words reset to zero, so every lookup then returns 0x00.
- R2: A lookup with `lk_valid` high at a clock edge sets `res_valid` high after that edge, with its code on `res_prop`. When `lk_valid` is low at an edge, `res_valid` drops and `res_prop` keeps its previous value.
- R3: With no range and no legacy hit, an address whose page (bits [31:12]) is below the top-of-memory field (default word bits [27:8]) gets the system code (bits [7:0]).
- R4: With no override, a page at or above top of memory and below the ROM base (bits [55:36]) gets the device code (bits [35:28]).
- R5: With no override, a page at or above both top of memory and ROM base gets the ROM code (bits [63:56]).
- R6: Legacy word (select 1):
  - Bit 48 enables the window. Bits [8k+7:8k] hold the code for 64 KB block k, at address 0xA0000 + k·0x10000, for k = 0..5.
  - When the window is enabled, an address in the window takes its block's code over any default zone.
  - When the window is disabled, addresses in the window fall back to the zones.
- R7: Range word (select 2+i, for i = 0..7):
  - Bits [63:44] hold the inclusive end page and bits [43:24] the start page. Bit 8 is the enable and bits [7:0] the code.
  - An enabled range containing the page overrides both the legacy window and the default zones.
  - A disabled range has no effect.
- R8: When several enabled ranges contain the page, the lowest-numbered one supplies the code.
- R9: A write (select 0 = default word) in the same cycle as a lookup leaves that lookup on the old settings, and the next lookup sees the new ones. Selects 10 and above are ignored.
- R10: Default word 0x25FFFC02_1077DF00 decodes as follows:
  - system code 0x00 below 0x077DF000;
  - device code 0x21 from 0x077DF000 up to 0xFFFBFFFF;
  - ROM code 0x25 from 0xFFFC0000 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cfg_we | input | 1 | Setting word write strobe |
| cfg_sel | input | 4 | Word select: 0 default, 1 legacy, 2..9 ranges |
| cfg_wdata | input | 64 | Setting word data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Physical address to look up |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_prop | output | 8 | Property code of the looked-up address |

## Verification
A setting write and a lookup can land on the same clock edge. The bench provokes this by issuing a default-word write and a lookup in the same cycle. It expects the old system code for that lookup and the new code for the lookup that follows.

Range and legacy overrides can also be live for the same address at once. Overlapping ranges are placed inside the legacy window and across the top-of-memory threshold. A full page sweep of the first megabyte, plus a pseudo-random sweep of the whole space, is compared against an arithmetic priority model.

// File: rtl/crl_pkg.sv
package crl_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = 20;
  localparam int ADDR_W     = PAGE_W + PAGE_SHIFT;
  localparam int PROP_W     = 8;
  localparam int WORD_W     = 64;
  localparam int LEG_BLKS   = 6;
  localparam logic [3:0] LEG_FIRST_BLK = 4'hA;

  typedef struct packed {
    logic [PROP_W-1:0] rom_prop;
    logic [PAGE_W-1:0] rom_base;
    logic [PROP_W-1:0] dev_prop;
    logic [PAGE_W-1:0] sys_top;
    logic [PROP_W-1:0] sys_prop;
  } dflt_t;

  typedef struct packed {
    logic [WORD_W-LEG_BLKS*PROP_W-2:0] rsvd;
    logic                              en;
    logic [LEG_BLKS-1:0][PROP_W-1:0]   prop;
  } leg_t;

  typedef struct packed {
    logic [PAGE_W-1:0]                 end_pg;
    logic [PAGE_W-1:0]                 start_pg;
    logic [WORD_W-2*PAGE_W-PROP_W-2:0] rsvd;
    logic                              en;
    logic [PROP_W-1:0]                 prop;
  } range_t;
endpackage

// File: rtl/crl_range_match.sv
module crl_range_match
  import crl_pkg::*;
(
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic              en,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  logic above_start;
  logic below_end;

  always_comb begin
    above_start = (page >= start_pg);
    below_end   = (page <= end_pg);
    hit         = en && above_start && below_end;
  end
endmodule

// File: rtl/crl_prio_pick.sv
module crl_prio_pick
  import crl_pkg::*;
#(
  parameter int NUM_RANGES = 8
) (
  input  logic [NUM_RANGES-1:0]             hit,
  input  logic [NUM_RANGES-1:0][PROP_W-1:0] props,
  output logic [NUM_RANGES-1:0]             grant,
  output logic                              any_hit,
  output logic [PROP_W-1:0]                 prop
);
  always_comb begin
    grant   = '0;
    any_hit = 1'b0;
    prop    = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        any_hit  = 1'b1;
        prop     = props[i];
      end
    end
  end
endmodule

// File: rtl/crl_zone_decode.sv
module crl_zone_decode
  import crl_pkg::*;
(
  input  dflt_t                           dflt,
  input  logic                            leg_en,
  input  logic [LEG_BLKS-1:0][PROP_W-1:0] leg_prop,
  input  logic [PAGE_W-1:0]               page,
  output logic                            leg_hit,
  output logic [PROP_W-1:0]               prop
);
  logic              in_window;
  logic [PROP_W-1:0] zone_prop;
  logic [PROP_W-1:0] blk_prop;

  always_comb begin
    in_window = (page[PAGE_W-1:8] == '0) && (page[7:4] >= LEG_FIRST_BLK);
    leg_hit   = leg_en && in_window;

    if (page < dflt.sys_top) begin
      zone_prop = dflt.sys_prop;
    end else if (page < dflt.rom_base) begin
      zone_prop = dflt.dev_prop;
    end else begin
      zone_prop = dflt.rom_prop;
    end

    blk_prop = '0;
    for (int k = 0; k < LEG_BLKS; k++) begin
      if (page[7:4] == LEG_FIRST_BLK + 4'(k)) begin
        blk_prop = leg_prop[k];
      end
    end

    prop = leg_hit ? blk_prop : zone_prop;
  end
endmodule

// File: rtl/cache_region_lookup.sv
module cache_region_lookup
  import crl_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  localparam int NUM_WORDS  = NUM_RANGES + 2,
  localparam int SEL_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic [PROP_W-1:0] res_prop
);
  localparam logic [SEL_W-1:0] SEL_DFLT = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_LEG  = SEL_W'(1);

  // setting words: next state and registers
  dflt_t                        dflt_q, dflt_d;
  leg_t                         leg_q, leg_d;
  range_t [NUM_RANGES-1:0]      rng_q, rng_d;

  always_comb begin
    dflt_d = dflt_q;
    leg_d  = leg_q;
    rng_d  = rng_q;
    if (cfg_we) begin
      if (cfg_sel == SEL_DFLT) begin
        dflt_d = dflt_t'(cfg_wdata);
      end else if (cfg_sel == SEL_LEG) begin
        leg_d = leg_t'(cfg_wdata);
      end else begin
        for (int i = 0; i < NUM_RANGES; i++) begin
          if (cfg_sel == SEL_W'(i + 2)) begin
            rng_d[i] = range_t'(cfg_wdata);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_q <= '0;
      leg_q  <= '0;
      rng_q  <= '0;
    end else begin
      dflt_q <= dflt_d;
      leg_q  <= leg_d;
      rng_q  <= rng_d;
    end
  end

  // lookup datapath
  logic [PAGE_W-1:0]                 lk_page;
  logic [NUM_RANGES-1:0]             hit_vec;
  logic [NUM_RANGES-1:0]             grant_vec;
  logic [NUM_RANGES-1:0][PROP_W-1:0] rng_props;
  logic [NUM_RANGES-1:0]             rsvd_fold;
  logic                              rng_any;
  logic [PROP_W-1:0]                 rng_prop;
  logic                              leg_hit;
  logic [PROP_W-1:0]                 zone_prop;
  logic [PROP_W-1:0]                 prop_d;
  logic                              unused_bits;

  assign lk_page = lk_addr[ADDR_W-1:PAGE_SHIFT];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    assign rng_props[g] = rng_q[g].prop;
    assign rsvd_fold[g] = ^rng_q[g].rsvd;
    crl_range_match u_match (
      .start_pg (rng_q[g].start_pg),
      .end_pg   (rng_q[g].end_pg),
      .en       (rng_q[g].en),
      .page     (lk_page),
      .hit      (hit_vec[g])
    );
  end

  crl_prio_pick #(.NUM_RANGES(NUM_RANGES)) u_pick (
    .hit     (hit_vec),
    .props   (rng_props),
    .grant   (grant_vec),
    .any_hit (rng_any),
    .prop    (rng_prop)
  );

  crl_zone_decode u_zone (
    .dflt     (dflt_q),
    .leg_en   (leg_q.en),
    .leg_prop (leg_q.prop),
    .page     (lk_page),
    .leg_hit  (leg_hit),
    .prop     (zone_prop)
  );

  assign prop_d      = rng_any ? rng_prop : zone_prop;
  assign unused_bits = ^{lk_addr[PAGE_SHIFT-1:0], leg_q.rsvd, rsvd_fold};

  // result register with clock enable on the code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_prop  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_prop <= prop_d;
      end
    end
  end
endmodule

// File: rtl/crl_checker.sv
module crl_checker
  import crl_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  localparam int NUM_WORDS  = NUM_RANGES + 2,
  localparam int SEL_W      = $clog2(NUM_WORDS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [SEL_W-1:0]      cfg_sel,
  input logic                  lk_valid,
  input logic [PAGE_W-1:0]     lk_page,
  input logic                  res_valid,
  input logic [PROP_W-1:0]     res_prop,
  input logic [WORD_W-1:0]     dflt_q,
  input logic [WORD_W-1:0]     leg_q,
  input logic [NUM_RANGES-1:0] hit_vec,
  input logic [NUM_RANGES-1:0] grant_vec,
  input logic                  leg_hit
);
  dflt_t d;
  logic  no_ovr;
  assign d      = dflt_t'(dflt_q);
  assign no_ovr = lk_valid && !(|hit_vec) && !leg_hit;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  // R2
  prop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(res_prop));
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  // R8
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> ((grant_vec != '0) && ((grant_vec & hit_vec) == grant_vec)
                    && ((hit_vec & (grant_vec - 1'b1)) == '0)));
  // R3
  sys_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && (lk_page < d.sys_top)) |=> (res_prop == $past(d.sys_prop)));
  // R4
  dev_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && (lk_page >= d.sys_top) && (lk_page < d.rom_base))
    |=> (res_prop == $past(d.dev_prop)));
  // R5
  rom_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && (lk_page >= d.sys_top) && (lk_page >= d.rom_base))
    |=> (res_prop == $past(d.rom_prop)));
  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel >= SEL_W'(NUM_WORDS))) |=> ($stable(dflt_q) && $stable(leg_q)));
endmodule

bind cache_region_lookup crl_checker #(.NUM_RANGES(NUM_RANGES)) u_crl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .lk_valid  (lk_valid),
  .lk_page   (lk_page),
  .res_valid (res_valid),
  .res_prop  (res_prop),
  .dflt_q    (dflt_q),
  .leg_q     (leg_q),
  .hit_vec   (hit_vec),
  .grant_vec (grant_vec),
  .leg_hit   (leg_hit)
);

// File: tb/cache_region_lookup_bench.sv
module cache_region_lookup_bench;
  localparam int NR    = 8;
  localparam int SEL_W = $clog2(NR + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [SEL_W-1:0]  cfg_sel = '0;
  logic [63:0]       cfg_wdata = '0;
  logic              lk_valid = 1'b0;
  logic [31:0]       lk_addr = '0;
  logic              res_valid;
  logic [7:0]        res_prop;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] m_dflt = '0;
  logic [63:0] m_leg  = '0;
  logic [63:0] m_rng [NR];

  always #4 clk = ~clk;

  cache_region_lookup #(.NUM_RANGES(NR)) u_cache_region_lookup (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_prop(res_prop)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input logic [31:0] a);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%08h actual=%0h expected=%0h", req, a, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SEL_W'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) m_dflt = data;
    else if (sel == 1) m_leg = data;
    else if (sel < NR + 2) m_rng[sel-2] = data;
  endtask

  // arithmetic model of the priority rules
  task automatic model(input logic [31:0] a, output logic [7:0] p, output string tag);
    logic [19:0] pg;
    int nhit;
    pg = a[31:12]; nhit = 0; p = 8'h00; tag = "";
    for (int i = 0; i < NR; i++) begin
      if (m_rng[i][8] && pg >= m_rng[i][43:24] && pg <= m_rng[i][63:44]) begin
        if (nhit == 0) p = m_rng[i][7:0];
        nhit++;
      end
    end
    if (nhit > 1) tag = "R8";
    else if (nhit == 1) tag = "R7";
    else if (m_leg[48] && a < 32'h100000 && a >= 32'hA0000) begin
      p = m_leg[8*(int'(a[19:16]) - 10) +: 8]; tag = "R6";
    end else if (pg < m_dflt[27:8]) begin p = m_dflt[7:0]; tag = "R3"; end
    else if (pg < m_dflt[55:36]) begin p = m_dflt[35:28]; tag = "R4"; end
    else begin p = m_dflt[63:56]; tag = "R5"; end
  endtask

  task automatic lookup(input logic [31:0] a, output logic [7:0] got);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    got = res_prop;
    check("R2", {63'b0, res_valid}, 64'd1, a);
  endtask

  task automatic probe(input logic [31:0] a);
    logic [7:0] got, exp;
    string tag;
    model(a, exp, tag);
    lookup(a, got);
    check(tag, {56'b0, got}, {56'b0, exp}, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  got, held;
    logic [31:0] x;
    for (int i = 0; i < NR; i++) m_rng[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check("R1", {63'b0, res_valid}, 64'd0, 0);
    check("R1", {56'b0, res_prop}, 64'd0, 0);
    lookup(32'h1234_5000, got);
    check("R1", {56'b0, got}, 64'd0, 32'h1234_5000);

    // R10 example default word
    wr(0, 64'h25FF_FC02_1077_DF00);
    lookup(32'h077D_EFFF, got); check("R10", {56'b0, got}, 64'h00, 32'h077DEFFF);
    lookup(32'h077D_F000, got); check("R10", {56'b0, got}, 64'h21, 32'h077DF000);
    lookup(32'hFFFB_FFFF, got); check("R10", {56'b0, got}, 64'h21, 32'hFFFBFFFF);
    lookup(32'hFFFC_0000, got); check("R10", {56'b0, got}, 64'h25, 32'hFFFC0000);
    probe(32'h0000_0000); probe(32'h8000_0000); probe(32'hFFFF_FFFF);

    // R6 legacy window disabled, then enabled
    wr(1, 64'h0000_0F0E_0D0C_0B0A);
    for (int pg = 0; pg < 256; pg++) probe(32'(pg) << 12);
    wr(1, 64'h0001_0F0E_0D0C_0B0A);
    for (int pg = 0; pg < 256; pg++) probe(32'(pg) << 12);

    // R7 / R8 ranges, overlapping and across thresholds
    wr(2, {20'h000CF, 20'h000C0, 15'b0, 1'b1, 8'h11});
    wr(3, {20'h00100, 20'h000C8, 15'b0, 1'b1, 8'h22});
    wr(5, {20'h07DFF, 20'h07700, 15'b0, 1'b1, 8'h33});
    wr(7, {20'h000FF, 20'h00000, 15'b0, 1'b0, 8'h44});
    wr(9, {20'hFFFFF, 20'hFFFF0, 15'b0, 1'b1, 8'h77});
    for (int pg = 0; pg < 264; pg++) probe(32'(pg) << 12);
    probe(32'h076F_FFFF); probe(32'h0770_0000); probe(32'h07DF_FFFF);
    probe(32'h07E0_0000); probe(32'hFFFE_FFFF); probe(32'hFFFF_0000);
    x = 32'h1357_9BDF;
    for (int k = 0; k < 4096; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      probe(x);
    end

    // R2 hold while idle
    lookup(32'h0770_0000, held);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2", {63'b0, res_valid}, 64'd0, 32'h0770_0000);
      check("R2", {56'b0, res_prop}, {56'b0, held}, 32'h0770_0000);
    end

    // R9 write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = '0; cfg_wdata = 64'h25FF_FC02_1077_DF99;
    lk_valid = 1'b1; lk_addr = 32'h0020_0000;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R9", {56'b0, res_prop}, 64'h00, 32'h0020_0000);
    m_dflt = 64'h25FF_FC02_1077_DF99;
    lookup(32'h0020_0000, got); check("R9", {56'b0, got}, 64'h99, 32'h0020_0000);

    // R9 out-of-range selects ignored
    wr(10, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(15, 64'h0);
    lookup(32'h0020_0000, got); check("R9", {56'b0, got}, 64'h99, 32'h0020_0000);
    lookup(32'h000A_0000, got); check("R9", {56'b0, got}, 64'h0A, 32'h000A_0000);
    lookup(32'h8000_0000, got); check("R9", {56'b0, got}, 64'h21, 32'h8000_0000);
    probe(32'h000C_8000); probe(32'hFFFF_F000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule